// File: doc/BRIEF.md
# Temperature Alarm Comparator

This block watches a stream of digital temperature samples and drives an active-low alarm line. Each sample is compared with three programmable limits: the top and bottom of an alarm window, and a critical trip point. Each comparison keeps its own condition flag. A flag is set as soon as its limit is crossed. It is released only after the temperature has moved back past the limit by a selectable hysteresis margin.

A small write port sets the three limits, the operating mode, the hysteresis amount and the enable. The same port carries a one-shot software clear. There are three operating modes. Interrupt mode latches an alarm until software clears it. Compare mode follows the window and critical flags directly. Critical-only mode reacts to the trip point alone. In every mode, a critical condition holds the line low for as long as it lasts, and software cannot clear it. The three condition flags can be read at any time as a status word, so software can see why the alarm was raised.

Temperature and limits are 13-bit two's-complement words with 1/16 °C per LSB. The supported range is −40 °C to +125 °C.

Top module: `temp_alarm`

## Requirements
- R1: After reset `alarm_no` is 1, `status_o` is 0 and the block is disabled. The default limits are upper 1360 (85 °C), lower 0 and critical 1520 (95 °C).
- R2: A write with `wr_en_i` high updates one register at the clock edge. Address 0 is control: bits [1:0] select the mode (0 interrupt, 1 compare, 2 or 3 critical-only), bit 2 is enable, bits [4:3] select hysteresis (0, 24, 48 or 96 LSB), and bit 5 written as 1 is a one-shot clear. Addresses 1, 2 and 3 hold the upper, lower and critical limits as signed 13-bit values.
- R3: Status bit 0 (above window) is set by a sample greater than the upper limit. Once set, it stays set while samples are at or above upper minus hysteresis.
- R4: Status bit 1 (below window) is set by a sample less than the lower limit. Once set, it stays set while samples are at or below lower plus hysteresis.
- R5: Status bit 2 (critical) is set by a sample greater than the critical limit. Once set, it stays set while samples are at or above critical minus hysteresis.
- R6: Status flags change only at a clock edge where `temp_valid_i` is high, and they are visible right after that edge.
- R7: While the block is disabled, `alarm_no` stays 1 whatever the samples are.
- R8: In interrupt mode, a sample that sets any status flag latches the alarm. The alarm then stays low even after the flags release, until a clear is written.
- R9: A clear in interrupt mode takes effect at the edge that writes it. It is ignored while the critical flag is set.
- R10: In compare mode, `alarm_no` is 0 exactly while any status flag is set, and a clear has no effect.
- R11: In critical-only mode, `alarm_no` is 0 exactly while the critical flag is set. The window flags have no effect on it.
- R12: In every enabled mode, `alarm_no` is 0 while the critical flag is set, even after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | 13 | Temperature sample, signed, 1/16 °C per LSB |
| temp_valid_i | input | 1 | Sample strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 13 | Register write data |
| alarm_no | output | 1 | Alarm, active low |
| status_o | output | 3 | Condition flags: bit 0 above, bit 1 below, bit 2 critical |

## Verification
The assertions assume that limits are written only between samples, and that a flag is set by the sample and limit present at the sampling edge. The bench therefore separates every write from every sample by a full clock, and it keeps samples inside the 13-bit range with at least two bits of headroom for the limit ± hysteresis sums. The ramps step in units that land exactly on each limit and on each release point, so that the equality boundaries of R3–R5 are hit.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
  typedef enum logic [1:0] {
    MODE_INT   = 2'd0,
    MODE_CMP   = 2'd1,
    MODE_CRIT  = 2'd2,
    MODE_CRIT2 = 2'd3
  } mode_e;

  localparam int NUM_COND  = 3;
  localparam int COND_HI   = 0;
  localparam int COND_LO   = 1;
  localparam int COND_CRIT = 2;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_UPPER = 2'd1;
  localparam logic [1:0] ADDR_LOWER = 2'd2;
  localparam logic [1:0] ADDR_CRIT  = 2'd3;

  typedef struct packed {
    mode_e      mode;
    logic       en;
    logic [1:0] hyst_sel;
  } ctrl_t;
endpackage

// File: rtl/temp_alarm_regs.sv
module temp_alarm_regs
  import temp_alarm_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int HYST_UNIT = 24,
  parameter int RST_UPPER = 1360,
  parameter int RST_LOWER = 0,
  parameter int RST_CRIT  = 1520
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [1:0]                        wr_addr_i,
  input  logic [TEMP_W-1:0]                 wr_data_i,
  output ctrl_t                             ctrl_o,
  output logic [NUM_COND-1:0][TEMP_W-1:0]   lim_o,
  output logic [TEMP_W-1:0]                 hyst_o,
  output logic                              clr_o
);
  ctrl_t             ctrl_q;
  logic [TEMP_W-1:0] upper_q, lower_q, crit_q;
  logic              unused_hi;

  assign unused_hi = ^wr_data_i[TEMP_W-1:6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{mode: MODE_INT, en: 1'b0, hyst_sel: 2'd0};
      upper_q <= TEMP_W'(RST_UPPER);
      lower_q <= TEMP_W'(RST_LOWER);
      crit_q  <= TEMP_W'(RST_CRIT);
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_CTRL: begin
          ctrl_q.mode     <= mode_e'(wr_data_i[1:0]);
          ctrl_q.en       <= wr_data_i[2];
          ctrl_q.hyst_sel <= wr_data_i[4:3];
        end
        ADDR_UPPER: upper_q <= wr_data_i;
        ADDR_LOWER: lower_q <= wr_data_i;
        default:    crit_q  <= wr_data_i;
      endcase
    end
  end

  always_comb begin
    unique case (ctrl_q.hyst_sel)
      2'd0:    hyst_o = '0;
      2'd1:    hyst_o = TEMP_W'(HYST_UNIT);
      2'd2:    hyst_o = TEMP_W'(2 * HYST_UNIT);
      default: hyst_o = TEMP_W'(4 * HYST_UNIT);
    endcase
  end

  assign ctrl_o             = ctrl_q;
  assign lim_o[COND_HI]     = upper_q;
  assign lim_o[COND_LO]     = lower_q;
  assign lim_o[COND_CRIT]   = crit_q;
  assign clr_o              = wr_en_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[5];

  AST_LIMITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(upper_q) && $stable(lower_q) && $stable(crit_q)); // R2
endmodule

// File: rtl/temp_alarm_cmp.sv
module temp_alarm_cmp
  import temp_alarm_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [TEMP_W-1:0]               temp_i,
  input  logic                            valid_i,
  input  logic [NUM_COND-1:0][TEMP_W-1:0] lim_i,
  input  logic [TEMP_W-1:0]               hyst_i,
  output logic [NUM_COND-1:0]             flag_o,
  output logic [NUM_COND-1:0]             rise_o
);
  localparam int EXT_W = TEMP_W + 2;

  logic [NUM_COND-1:0]    flag_q;
  logic signed [EXT_W-1:0] t_x, h_x;

  assign t_x = {{2{temp_i[TEMP_W-1]}}, temp_i};
  assign h_x = {2'b00, hyst_i};

  for (genvar i = 0; i < NUM_COND; i++) begin : g_cond
    logic signed [EXT_W-1:0] l_x;
    logic                    set_c, hold_c, nxt;
    assign l_x = {{2{lim_i[i][TEMP_W-1]}}, lim_i[i]};
    if (i == COND_LO) begin : g_below
      assign set_c  = t_x < l_x;
      assign hold_c = t_x <= (l_x + h_x);
    end else begin : g_above
      assign set_c  = t_x > l_x;
      assign hold_c = t_x >= (l_x - h_x);
    end
    assign nxt       = flag_q[i] ? hold_c : set_c;
    assign rise_o[i] = valid_i && nxt && !flag_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[i] <= 1'b0;
      else if (valid_i) flag_q[i] <= nxt;
    end
  end

  assign flag_o = flag_q;

  AST_FLAGS_NEED_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flag_q)); // R6
  AST_HI_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[COND_HI]) |-> $signed($past(temp_i)) > $signed($past(lim_i[COND_HI]))); // R3
  AST_LO_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[COND_LO]) |-> $signed($past(temp_i)) < $signed($past(lim_i[COND_LO]))); // R4
endmodule

// File: rtl/temp_alarm_event.sv
module temp_alarm_event
  import temp_alarm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  logic                clr_i,
  input  logic [NUM_COND-1:0] flag_i,
  input  logic [NUM_COND-1:0] rise_i,
  output logic                alarm_no
);
  logic latch_q, int_mode, crit, win, active;

  assign int_mode = ctrl_i.en && (ctrl_i.mode == MODE_INT);
  assign crit     = flag_i[COND_CRIT];
  assign win      = flag_i[COND_HI] | flag_i[COND_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                latch_q <= 1'b0;
    else if (!int_mode)         latch_q <= 1'b0;
    else if (|rise_i)           latch_q <= 1'b1;
    else if (clr_i && !crit)    latch_q <= 1'b0;
  end

  always_comb begin
    unique case (ctrl_i.mode)
      MODE_INT: active = latch_q | crit;
      MODE_CMP: active = win | crit;
      default:  active = crit;
    endcase
  end

  assign alarm_no = !(ctrl_i.en && active);

  AST_CLR_BLOCKED_CRIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode && clr_i && crit && latch_q) |=> latch_q); // R9
  AST_CMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en && ctrl_i.mode == MODE_CMP && flag_i == '0) |-> alarm_no); // R10
  AST_CRIT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en && crit) |-> !alarm_no); // R12
endmodule

// File: rtl/temp_alarm.sv
module temp_alarm
  import temp_alarm_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int HYST_UNIT = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_valid_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [TEMP_W-1:0] wr_data_i,
  output logic              alarm_no,
  output logic [2:0]        status_o
);
  ctrl_t                           ctrl;
  logic [NUM_COND-1:0][TEMP_W-1:0] lim;
  logic [TEMP_W-1:0]               hyst;
  logic                            clr;
  logic [NUM_COND-1:0]             flag, rise;

  temp_alarm_regs #(.TEMP_W(TEMP_W), .HYST_UNIT(HYST_UNIT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .lim_o(lim), .hyst_o(hyst), .clr_o(clr)
  );

  temp_alarm_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .clk_i, .rst_ni, .temp_i, .valid_i(temp_valid_i),
    .lim_i(lim), .hyst_i(hyst), .flag_o(flag), .rise_o(rise)
  );

  temp_alarm_event u_event (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .clr_i(clr),
    .flag_i(flag), .rise_i(rise), .alarm_no
  );

  assign status_o = flag;

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl.en) && !ctrl.en |-> alarm_no); // R7
endmodule

// File: tb/temp_alarm_tb.sv
module temp_alarm_tb;
  localparam int TW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] temp = '0;
  logic          valid = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic          alarm_n;
  logic [2:0]    status;

  int n_chk = 0, n_fail = 0;
  int up = 1360, lo = 0, cr = 1520;
  int m_mode = 0, m_en = 0, m_h = 0;
  bit m_hi = 0, m_lo = 0, m_cr = 0, m_latch = 0;

  always #5 clk = ~clk;

  temp_alarm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .temp_i(temp), .temp_valid_i(valid),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .alarm_no(alarm_n), .status_o(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int hyst_of(input int sel);
    return (sel == 0) ? 0 : 24 << (sel - 1);
  endfunction

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = TW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ctrl(input int mode, input int en, input int hs, input bit clr);
    wr(2'd0, mode | (en << 2) | (hs << 3) | (int'(clr) << 5));
    if (clr && m_en == 1 && m_mode == 0 && !m_cr) m_latch = 0;
    m_mode = mode; m_en = en; m_h = hyst_of(hs);
    if (!(m_en == 1 && m_mode == 0)) m_latch = 0;
  endtask

  task automatic verify(input string tag);
    bit exp_act;
    if (m_en == 0)       exp_act = 0;
    else if (m_mode == 0) exp_act = m_latch | m_cr;
    else if (m_mode == 1) exp_act = m_hi | m_lo | m_cr;
    else                  exp_act = m_cr;
    check(alarm_n == !exp_act, tag, int'(alarm_n), int'(!exp_act));
    check(status == {m_cr, m_lo, m_hi}, "R3 R4 R5 status", int'(status),
          int'({m_cr, m_lo, m_hi}));
  endtask

  task automatic sample(input int t, input string tag);
    bit n_hi, n_lo, n_cr;
    @(negedge clk);
    temp = TW'(t); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    n_hi = m_hi ? (t >= up - m_h) : (t > up);
    n_lo = m_lo ? (t <= lo + m_h) : (t < lo);
    n_cr = m_cr ? (t >= cr - m_h) : (t > cr);
    if (m_en == 1 && m_mode == 0 &&
        ((n_hi && !m_hi) || (n_lo && !m_lo) || (n_cr && !m_cr))) m_latch = 1;
    m_hi = n_hi; m_lo = n_lo; m_cr = n_cr;
    verify(tag);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(alarm_n == 1'b1, "R1 alarm after reset", int'(alarm_n), 1);
    check(status == 3'b000, "R1 status after reset", int'(status), 0);

    // default limits, disabled then compare mode
    sample(1400, "R7 disabled ignores samples");
    sample(0, "R1 default upper");
    wr_ctrl(1, 1, 0, 0);
    sample(1360, "R1 default upper boundary");
    sample(1361, "R1 default upper exceeded");
    sample(1521, "R1 default crit exceeded");
    sample(-1, "R1 default lower exceeded");
    sample(-640, "R4 range bottom");
    sample(2000, "R5 range top");

    // program limits
    wr(2'd1, 400); up = 400;
    wr(2'd2, -160); lo = -160;
    wr(2'd3, 800); cr = 800;
    @(negedge clk);
    check(status == {m_cr, m_lo, m_hi}, "R6 no sample no change", int'(status),
          int'({m_cr, m_lo, m_hi}));

    for (int m = 0; m < 3; m++) begin
      for (int hs = 0; hs < 4; hs++) begin
        int k;
        wr_ctrl(m, 1, hs, 0);
        k = 0;
        for (int t = -400; t <= 1000; t += 8) begin
          sample(t, m == 0 ? "R8 ramp up" : (m == 1 ? "R10 ramp up" : "R11 ramp up"));
          k++;
          if (k % 20 == 0) begin
            wr_ctrl(m, 1, hs, 1);
            verify(m == 0 ? "R9 clear" : "R10 R11 clear ignored");
          end
        end
        for (int t = 1000; t >= -400; t -= 8) begin
          sample(t, m == 0 ? "R8 ramp down" : (m == 1 ? "R10 ramp down" : "R11 ramp down"));
          k++;
          if (k % 20 == 0) begin
            wr_ctrl(m, 1, hs, 1);
            verify(m == 0 ? "R9 clear" : "R10 R11 clear ignored");
          end
        end
      end
    end

    // targeted: interrupt latch with critical lockout
    wr_ctrl(0, 1, 1, 0);
    sample(0, "R8 idle");
    sample(900, "R12 crit raises");
    wr_ctrl(0, 1, 1, 1);
    check(alarm_n == 1'b0, "R9 clear blocked by crit", int'(alarm_n), 0);
    sample(500, "R8 latch holds after crit release");
    check(alarm_n == 1'b0, "R8 latched", int'(alarm_n), 0);
    wr_ctrl(0, 1, 1, 1);
    check(alarm_n == 1'b1, "R9 clear releases", int'(alarm_n), 1);
    sample(500, "R8 no new crossing");

    // compare mode: clear has no effect
    wr_ctrl(1, 1, 0, 0);
    sample(500, "R10 above window");
    wr_ctrl(1, 1, 0, 1);
    check(alarm_n == 1'b0, "R10 clear ignored", int'(alarm_n), 0);
    check(status[0] == 1'b1, "R10 status kept", int'(status[0]), 1);

    // critical-only: window has no effect
    wr_ctrl(2, 1, 0, 0);
    sample(-300, "R11 below window quiet");
    check(alarm_n == 1'b1, "R11 window ignored", int'(alarm_n), 1);
    sample(801, "R11 crit alarm");
    wr_ctrl(2, 1, 0, 1);
    check(alarm_n == 1'b0, "R12 crit not clearable", int'(alarm_n), 0);

    // disable
    wr_ctrl(1, 0, 0, 0);
    sample(900, "R7 disabled");
    check(alarm_n == 1'b1, "R7 disabled high", int'(alarm_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule